// File: doc/BRIEF.md
# Store-to-Load Forwarding Checker

This block sits beside a store queue and decides, for each executing load, where the load's data comes from. The load presents its byte address, its size, its load-queue slot, its age tag and the store-queue position it was given at allocation. The block walks the store queue from that position toward older entries and stops at the writeback pointer. The first store whose byte range touches the load settles the outcome.

If that store holds every byte the load needs, the block returns the aligned store word one cycle later and no cache port is used. If that store only partly overlaps the load and has not yet written back, the load is sent back for replay. The block then holds a stall record naming the store and the oldest such load. When that store reports writeback, the stall clears and the recorded load is released. If no store overlaps, the load goes to the cache. A load that arrives while the cache is blocked is instead held in a blocked record, and that record tracks the oldest such load. An uncacheable load that is not both at the load-queue head and at commit is rejected with a fault flag.

Top module: `stld_fwd_unit`

## Requirements
- R1: After synchronous reset, every valid output, the stall flag and the blocked flag are 0, and all store entries have size 0.
- R2: The search checks entries at `ld_sq_idx-1`, `ld_sq_idx-2`, ... modulo the queue depth, up to and including the entry at `wb_ptr`. When `ld_sq_idx == wb_ptr` no store is checked. The first overlapping store in that order decides the outcome, even when an older store would cover the load.
- R3: An entry whose size is 0 (never written, or freed through `st_free_en`) takes no part in the search.
- R4: A store covers a load when `ld_addr >= st_addr` and `ld_addr+ld_size <= st_addr+st_size`. Sizes are in bytes, stores are naturally aligned, and byte `st_addr+k` sits in data bits `8k+7:8k`. The cycle after the load, `fwd_vld` is 1, `fwd_lq_idx` equals the load slot and `fwd_data` equals the store word shifted right by `8*(ld_addr & (st_size-1))`. `cache_req_vld` stays 0.
- R5: A store that overlaps but does not cover the load, and has not completed, gives `replay_vld=1` with `replay_fault=0` on the next cycle. It also sets `stalled`, with `stall_st_seq` set to that store's age tag and `stall_lq_idx` set to the load slot.
- R6: A partly overlapping store that has completed is passed over and the search goes on. A completion signalled through `st_done_en` in the same cycle as the search counts as completed.
- R7: An existing stall record is replaced only by a load with a smaller age tag (older).
- R8: When `st_done_en` names the entry whose age tag equals `stall_st_seq` while stalled, then on the next cycle `stalled` is 0 and `release_vld` pulses for one cycle with `release_lq_idx` equal to the recorded slot. A completion of any other store leaves the record unchanged.
- R9: A load that overlaps no store in its search range raises `cache_req_vld` for one cycle with `cache_req_lq_idx` set to its slot, unless the cache is blocked.
- R10: A load with `ld_uncache=1` that is not both `ld_at_head` and `ld_at_commit` gives `replay_vld=1` and `replay_fault=1` on the next cycle. It neither forwards nor touches the stall record. An uncacheable load that is at head and at commit is handled like any other load.
- R11: A load bound for the cache while `cache_blocked=1` raises no cache request. On the next cycle it sets `ld_blocked` with `ld_blocked_seq` equal to its age tag, unless an older load is already recorded. `blk_clear` clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_wr_en | input | 1 | Write address, size, data and tag into a store entry |
| st_wr_idx | input | IDX_W | Entry written |
| st_wr_addr | input | ADDR_W | Store byte address |
| st_wr_size | input | SIZE_W | Store size in bytes (0 = no address yet) |
| st_wr_data | input | DATA_W | Store data word |
| st_wr_seq | input | SEQ_W | Store age tag |
| st_free_en | input | 1 | Free an entry (size back to 0) |
| st_free_idx | input | IDX_W | Entry freed |
| st_done_en | input | 1 | Store writeback completed |
| st_done_idx | input | IDX_W | Entry completed |
| wb_ptr | input | IDX_W | Oldest store not yet written back |
| ld_valid | input | 1 | A load executes this cycle |
| ld_addr | input | ADDR_W | Load byte address |
| ld_size | input | SIZE_W | Load size in bytes |
| ld_lq_idx | input | LQ_W | Load-queue slot |
| ld_sq_idx | input | IDX_W | Store-queue position at allocation |
| ld_seq | input | SEQ_W | Load age tag (smaller is older) |
| ld_uncache | input | 1 | Load is uncacheable |
| ld_at_head | input | 1 | Load is at the load-queue head |
| ld_at_commit | input | 1 | Load is ready to commit |
| cache_blocked | input | 1 | Cache cannot accept a request |
| blk_clear | input | 1 | Clear the blocked-load record |
| fwd_vld | output | 1 | Forwarded result valid |
| fwd_lq_idx | output | LQ_W | Slot of forwarded load |
| fwd_data | output | DATA_W | Forwarded, shifted data |
| replay_vld | output | 1 | Load must replay |
| replay_lq_idx | output | LQ_W | Slot of replayed load |
| replay_fault | output | 1 | Replay caused by an uncacheable rejection |
| cache_req_vld | output | 1 | Load sent to the cache (one port used) |
| cache_req_lq_idx | output | LQ_W | Slot of load sent to the cache |
| stalled | output | 1 | Partial-overlap stall active |
| stall_st_seq | output | SEQ_W | Age tag of the stalling store |
| stall_lq_idx | output | LQ_W | Slot of the recorded stalled load |
| release_vld | output | 1 | Recorded load released for replay |
| release_lq_idx | output | LQ_W | Slot of released load |
| ld_blocked | output | 1 | A load met a blocked cache |
| ld_blocked_seq | output | SEQ_W | Age tag of the oldest blocked load |

## Verification
The writeback completion of the stalling store and a new load search over that same store can land in one clock cycle. The bench sets up a stall on a store and then, in one cycle, drives that store's completion together with a second partly overlapping load. It expects, one cycle later, a release pulse for the first load, a cache request for the second load instead of a replay, and the stall flag cleared, which shows that the completion bypass and the release ordering agree.

// File: rtl/stld_pkg.sv
`timescale 1ns/1ps
package stld_pkg;
  typedef enum logic [1:0] {
    HIT_NONE = 2'd0,
    HIT_FWD  = 2'd1,
    HIT_PART = 2'd2
  } hit_e;
endpackage

// File: rtl/stld_entry_file.sv
`timescale 1ns/1ps
module stld_entry_file #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int SEQ_W  = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [$clog2(DEPTH)-1:0]          wr_idx,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic [$clog2(DATA_W/8):0]         wr_size,
  input  logic [DATA_W-1:0]                 wr_data,
  input  logic [SEQ_W-1:0]                  wr_seq,
  input  logic                              free_en,
  input  logic [$clog2(DEPTH)-1:0]          free_idx,
  input  logic                              done_en,
  input  logic [$clog2(DEPTH)-1:0]          done_idx,
  output logic [DEPTH-1:0][ADDR_W-1:0]      e_addr,
  output logic [DEPTH-1:0][$clog2(DATA_W/8):0] e_size,
  output logic [DEPTH-1:0][DATA_W-1:0]      e_data,
  output logic [DEPTH-1:0][SEQ_W-1:0]       e_seq,
  output logic [DEPTH-1:0]                  e_done_eff
);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int SIZE_W = $clog2(DATA_W/8) + 1;

  logic [DEPTH-1:0] done_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic hit_wr, hit_free, hit_done;
    assign hit_wr   = wr_en   && (wr_idx   == IDX_W'(i));
    assign hit_free = free_en && (free_idx == IDX_W'(i));
    assign hit_done = done_en && (done_idx == IDX_W'(i));

    // payload fields carry no reset so they map onto plain flops / LUT RAM
    always_ff @(posedge clk) begin
      if (hit_wr) begin
        e_addr[i] <= wr_addr;
        e_data[i] <= wr_data;
        e_seq[i]  <= wr_seq;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        e_size[i] <= '0;
        done_q[i] <= 1'b0;
      end else if (hit_wr) begin
        e_size[i] <= wr_size;
        done_q[i] <= 1'b0;
      end else begin
        if (hit_free) e_size[i] <= SIZE_W'(0);
        if (hit_done) done_q[i] <= 1'b1;
      end
    end

    // a completion arriving this cycle is visible to the search at once
    assign e_done_eff[i] = done_q[i] | hit_done;
  end
endmodule

// File: rtl/stld_scan.sv
`timescale 1ns/1ps
module stld_scan import stld_pkg::*; #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int SEQ_W  = 16
) (
  input  logic [DEPTH-1:0][ADDR_W-1:0]         e_addr,
  input  logic [DEPTH-1:0][$clog2(DATA_W/8):0] e_size,
  input  logic [DEPTH-1:0][DATA_W-1:0]         e_data,
  input  logic [DEPTH-1:0][SEQ_W-1:0]          e_seq,
  input  logic [DEPTH-1:0]                     e_done_eff,
  input  logic [$clog2(DEPTH)-1:0]             start_idx,
  input  logic [$clog2(DEPTH)-1:0]             stop_idx,
  input  logic [ADDR_W-1:0]                    ld_addr,
  input  logic [$clog2(DATA_W/8):0]            ld_size,
  output hit_e                                 kind,
  output logic [DATA_W-1:0]                    hit_data,
  output logic [SEQ_W-1:0]                     hit_seq
);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int SIZE_W = $clog2(DATA_W/8) + 1;
  localparam int AW1    = ADDR_W + 1;

  always_comb begin
    logic [IDX_W-1:0]  cur;
    logic              stop;
    logic [AW1-1:0]    ls, le, ss, se;
    logic [SIZE_W-1:0] off;
    kind     = HIT_NONE;
    hit_data = '0;
    hit_seq  = '0;
    cur      = start_idx;
    stop     = 1'b0;
    off      = '0;
    ls       = {1'b0, ld_addr};
    le       = ls + AW1'(ld_size);
    ss       = '0;
    se       = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (!stop) begin
        if (cur == stop_idx) begin
          stop = 1'b1;
        end else begin
          cur = cur - IDX_W'(1);
          if (e_size[cur] != SIZE_W'(0)) begin
            ss = {1'b0, e_addr[cur]};
            se = ss + AW1'(e_size[cur]);
            if (ls >= ss && le <= se) begin
              off      = ld_addr[SIZE_W-1:0] & (e_size[cur] - SIZE_W'(1));
              hit_data = e_data[cur] >> {off, 3'b000};
              hit_seq  = e_seq[cur];
              kind     = HIT_FWD;
              stop     = 1'b1;
            end else if (ls < se && le > ss && !e_done_eff[cur]) begin
              hit_seq = e_seq[cur];
              kind    = HIT_PART;
              stop    = 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/stld_stall_track.sv
`timescale 1ns/1ps
module stld_stall_track #(
  parameter int SEQ_W = 16,
  parameter int LQ_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             part_hit,
  input  logic [SEQ_W-1:0] ld_seq,
  input  logic [LQ_W-1:0]  ld_lq_idx,
  input  logic [SEQ_W-1:0] hit_st_seq,
  input  logic             done_en,
  input  logic [SEQ_W-1:0] done_seq,
  output logic             stalled_q,
  output logic [SEQ_W-1:0] st_seq_q,
  output logic [LQ_W-1:0]  lq_idx_q,
  output logic             rel_vld_q,
  output logic [LQ_W-1:0]  rel_idx_q
);
  logic [SEQ_W-1:0] ld_seq_q;
  logic             releasing, take;

  assign releasing = stalled_q && done_en && (done_seq == st_seq_q);
  assign take      = part_hit && (!stalled_q || releasing || (ld_seq < ld_seq_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      stalled_q <= 1'b0;
      st_seq_q  <= '0;
      lq_idx_q  <= '0;
      ld_seq_q  <= '0;
      rel_vld_q <= 1'b0;
      rel_idx_q <= '0;
    end else begin
      rel_vld_q <= releasing;
      if (releasing) rel_idx_q <= lq_idx_q;
      if (take) begin
        stalled_q <= 1'b1;
        st_seq_q  <= hit_st_seq;
        lq_idx_q  <= ld_lq_idx;
        ld_seq_q  <= ld_seq;
      end else if (releasing) begin
        stalled_q <= 1'b0;
      end
    end
  end

  // R8
  release_src_chk: assert property (@(posedge clk) disable iff (rst)
    rel_vld_q |-> $past(stalled_q));

  // R7
  older_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (stalled_q && !releasing) |=> (ld_seq_q <= $past(ld_seq_q)));
endmodule

// File: rtl/stld_fwd_unit.sv
`timescale 1ns/1ps
module stld_fwd_unit import stld_pkg::*; #(
  parameter int SQ_DEPTH = 8,
  parameter int LQ_DEPTH = 8,
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 64,
  parameter int SEQ_W    = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          st_wr_en,
  input  logic [$clog2(SQ_DEPTH)-1:0]   st_wr_idx,
  input  logic [ADDR_W-1:0]             st_wr_addr,
  input  logic [$clog2(DATA_W/8):0]     st_wr_size,
  input  logic [DATA_W-1:0]             st_wr_data,
  input  logic [SEQ_W-1:0]              st_wr_seq,
  input  logic                          st_free_en,
  input  logic [$clog2(SQ_DEPTH)-1:0]   st_free_idx,
  input  logic                          st_done_en,
  input  logic [$clog2(SQ_DEPTH)-1:0]   st_done_idx,
  input  logic [$clog2(SQ_DEPTH)-1:0]   wb_ptr,
  input  logic                          ld_valid,
  input  logic [ADDR_W-1:0]             ld_addr,
  input  logic [$clog2(DATA_W/8):0]     ld_size,
  input  logic [$clog2(LQ_DEPTH)-1:0]   ld_lq_idx,
  input  logic [$clog2(SQ_DEPTH)-1:0]   ld_sq_idx,
  input  logic [SEQ_W-1:0]              ld_seq,
  input  logic                          ld_uncache,
  input  logic                          ld_at_head,
  input  logic                          ld_at_commit,
  input  logic                          cache_blocked,
  input  logic                          blk_clear,
  output logic                          fwd_vld,
  output logic [$clog2(LQ_DEPTH)-1:0]   fwd_lq_idx,
  output logic [DATA_W-1:0]             fwd_data,
  output logic                          replay_vld,
  output logic [$clog2(LQ_DEPTH)-1:0]   replay_lq_idx,
  output logic                          replay_fault,
  output logic                          cache_req_vld,
  output logic [$clog2(LQ_DEPTH)-1:0]   cache_req_lq_idx,
  output logic                          stalled,
  output logic [SEQ_W-1:0]              stall_st_seq,
  output logic [$clog2(LQ_DEPTH)-1:0]   stall_lq_idx,
  output logic                          release_vld,
  output logic [$clog2(LQ_DEPTH)-1:0]   release_lq_idx,
  output logic                          ld_blocked,
  output logic [SEQ_W-1:0]              ld_blocked_seq
);
  localparam int IDX_W  = $clog2(SQ_DEPTH);
  localparam int LQ_W   = $clog2(LQ_DEPTH);
  localparam int SIZE_W = $clog2(DATA_W/8) + 1;

  logic [SQ_DEPTH-1:0][ADDR_W-1:0] e_addr;
  logic [SQ_DEPTH-1:0][SIZE_W-1:0] e_size;
  logic [SQ_DEPTH-1:0][DATA_W-1:0] e_data;
  logic [SQ_DEPTH-1:0][SEQ_W-1:0]  e_seq;
  logic [SQ_DEPTH-1:0]             e_done_eff;
  hit_e                            kind;
  logic [DATA_W-1:0]               hit_data;
  logic [SEQ_W-1:0]                hit_seq;

  stld_entry_file #(.DEPTH(SQ_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEQ_W(SEQ_W)) u_ents (
    .clk(clk), .rst(rst),
    .wr_en(st_wr_en), .wr_idx(st_wr_idx), .wr_addr(st_wr_addr), .wr_size(st_wr_size),
    .wr_data(st_wr_data), .wr_seq(st_wr_seq),
    .free_en(st_free_en), .free_idx(st_free_idx),
    .done_en(st_done_en), .done_idx(st_done_idx),
    .e_addr(e_addr), .e_size(e_size), .e_data(e_data), .e_seq(e_seq), .e_done_eff(e_done_eff)
  );

  stld_scan #(.DEPTH(SQ_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEQ_W(SEQ_W)) u_scan (
    .e_addr(e_addr), .e_size(e_size), .e_data(e_data), .e_seq(e_seq), .e_done_eff(e_done_eff),
    .start_idx(ld_sq_idx), .stop_idx(wb_ptr), .ld_addr(ld_addr), .ld_size(ld_size),
    .kind(kind), .hit_data(hit_data), .hit_seq(hit_seq)
  );

  // load disposition
  logic unc_reject, go, is_fwd, is_part, is_mem, send, blk;
  assign unc_reject = ld_uncache && !(ld_at_head && ld_at_commit);
  assign go         = ld_valid && !unc_reject;
  assign is_fwd     = go && (kind == HIT_FWD);
  assign is_part    = go && (kind == HIT_PART);
  assign is_mem     = go && (kind == HIT_NONE);
  assign send       = is_mem && !cache_blocked;
  assign blk        = is_mem && cache_blocked;

  stld_stall_track #(.SEQ_W(SEQ_W), .LQ_W(LQ_W)) u_stall (
    .clk(clk), .rst(rst),
    .part_hit(is_part), .ld_seq(ld_seq), .ld_lq_idx(ld_lq_idx), .hit_st_seq(hit_seq),
    .done_en(st_done_en), .done_seq(e_seq[st_done_idx]),
    .stalled_q(stalled), .st_seq_q(stall_st_seq), .lq_idx_q(stall_lq_idx),
    .rel_vld_q(release_vld), .rel_idx_q(release_lq_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_vld          <= 1'b0;
      replay_vld       <= 1'b0;
      replay_fault     <= 1'b0;
      cache_req_vld    <= 1'b0;
      fwd_lq_idx       <= '0;
      fwd_data         <= '0;
      replay_lq_idx    <= '0;
      cache_req_lq_idx <= '0;
    end else begin
      fwd_vld       <= is_fwd;
      replay_vld    <= is_part || (ld_valid && unc_reject);
      replay_fault  <= ld_valid && unc_reject;
      cache_req_vld <= send;
      if (is_fwd) begin
        fwd_lq_idx <= ld_lq_idx;
        fwd_data   <= hit_data;
      end
      if (ld_valid) replay_lq_idx <= ld_lq_idx;
      if (send) cache_req_lq_idx <= ld_lq_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_blocked     <= 1'b0;
      ld_blocked_seq <= '0;
    end else if (blk && (!ld_blocked || blk_clear || ld_seq < ld_blocked_seq)) begin
      ld_blocked     <= 1'b1;
      ld_blocked_seq <= ld_seq;
    end else if (blk_clear) begin
      ld_blocked <= 1'b0;
    end
  end

  // R4 R9 R10
  one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fwd_vld, replay_vld, cache_req_vld}));

  // R10
  unc_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && ld_uncache && !(ld_at_head && ld_at_commit)) |=> (replay_vld && replay_fault && !fwd_vld));

  // R2
  empty_window_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && !ld_uncache && ld_sq_idx == wb_ptr) |=> (!fwd_vld && !replay_vld));

  // R11
  blocked_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && cache_blocked) |=> !cache_req_vld);

  // R11
  blocked_oldest_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_blocked && !blk_clear) |=> (ld_blocked && ld_blocked_seq <= $past(ld_blocked_seq)));
endmodule

// File: tb/stld_fwd_unit_test.sv
`timescale 1ns/1ps
module stld_fwd_unit_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        st_wr_en = 0, st_free_en = 0, st_done_en = 0;
  logic [2:0]  st_wr_idx = 0, st_free_idx = 0, st_done_idx = 0, wb_ptr = 0;
  logic [31:0] st_wr_addr = 0;
  logic [3:0]  st_wr_size = 0;
  logic [63:0] st_wr_data = 0;
  logic [15:0] st_wr_seq = 0;
  logic        ld_valid = 0, ld_uncache = 0, ld_at_head = 0, ld_at_commit = 0;
  logic [31:0] ld_addr = 0;
  logic [3:0]  ld_size = 0;
  logic [2:0]  ld_lq_idx = 0, ld_sq_idx = 0;
  logic [15:0] ld_seq = 0;
  logic        cache_blocked = 0, blk_clear = 0;
  logic        fwd_vld, replay_vld, replay_fault, cache_req_vld, stalled, release_vld, ld_blocked;
  logic [2:0]  fwd_lq_idx, replay_lq_idx, cache_req_lq_idx, stall_lq_idx, release_lq_idx;
  logic [63:0] fwd_data;
  logic [15:0] stall_st_seq, ld_blocked_seq;

  stld_fwd_unit uut (.*);

  int tests = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr_store(input [2:0] i, input [31:0] a, input [3:0] s, input [63:0] d, input [15:0] q);
    @(negedge clk);
    st_wr_en = 1; st_wr_idx = i; st_wr_addr = a; st_wr_size = s; st_wr_data = d; st_wr_seq = q;
    @(negedge clk);
    st_wr_en = 0;
  endtask

  task automatic done_store(input [2:0] i);
    @(negedge clk);
    st_done_en = 1; st_done_idx = i;
    @(negedge clk);
    st_done_en = 0;
  endtask

  task automatic load(input [31:0] a, input [3:0] s, input [2:0] lq, input [2:0] sqi, input [2:0] wbp,
                      input [15:0] q, input bit unc, input bit hc);
    @(negedge clk);
    ld_valid = 1; ld_addr = a; ld_size = s; ld_lq_idx = lq; ld_sq_idx = sqi; wb_ptr = wbp;
    ld_seq = q; ld_uncache = unc; ld_at_head = hc; ld_at_commit = hc;
    @(negedge clk);
    ld_valid = 0; ld_uncache = 0;
  endtask

  task automatic preload();
    wr_store(0, 32'h100, 8, 64'h8877665544332211, 10);
    wr_store(1, 32'h200, 4, 64'h00000000DDCCBBAA, 11);
    wr_store(3, 32'h204, 4, 64'h0000000012345678, 13);
    wr_store(4, 32'h300, 2, 64'h000000000000BEEF, 14);
    wr_store(5, 32'h100, 2, 64'h000000000000AAAA, 15);
    wr_store(7, 32'h400, 8, 64'h0123456789ABCDEF, 17);
    done_store(4);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
  endtask

  // kind: 1 forward, 2 replay, 3 replay with fault, 4 cache request
  typedef struct packed {
    logic [31:0] addr; logic [3:0] size; logic [2:0] sqi; logic [2:0] wbp;
    logic unc; logic hc; logic [2:0] kind; logic [63:0] data;
  } vec_t;

  localparam vec_t TBL [15] = '{
    '{32'h100, 4'd8, 3'd1, 3'd0, 1'b0, 1'b0, 3'd1, 64'h8877665544332211}, // R4 whole word
    '{32'h104, 4'd4, 3'd1, 3'd0, 1'b0, 1'b0, 3'd1, 64'h0000000088776655}, // R4 upper half
    '{32'h102, 4'd2, 3'd6, 3'd0, 1'b0, 1'b0, 3'd1, 64'h0000887766554433}, // R2 R3 deep walk
    '{32'h100, 4'd4, 3'd6, 3'd0, 1'b0, 1'b0, 3'd2, 64'h0},                // R2 youngest partial wins
    '{32'h300, 4'd2, 3'd5, 3'd0, 1'b0, 1'b0, 3'd1, 64'h000000000000BEEF}, // R4 done store covers
    '{32'h300, 4'd4, 3'd5, 3'd0, 1'b0, 1'b0, 3'd4, 64'h0},                // R6 done partial skipped
    '{32'h404, 4'd4, 3'd0, 3'd7, 1'b0, 1'b0, 3'd1, 64'h0000000001234567}, // R2 wraparound
    '{32'h100, 4'd8, 3'd1, 3'd1, 1'b0, 1'b0, 3'd4, 64'h0},                // R2 empty window
    '{32'h100, 4'd8, 3'd2, 3'd1, 1'b0, 1'b0, 3'd4, 64'h0},                // R2 stops at wb_ptr
    '{32'h206, 4'd2, 3'd4, 3'd0, 1'b0, 1'b0, 3'd1, 64'h0000000000001234}, // R4 offset 2
    '{32'h202, 4'd4, 3'd4, 3'd0, 1'b0, 1'b0, 3'd2, 64'h0},                // R5 straddle
    '{32'h600, 4'd8, 3'd4, 3'd0, 1'b0, 1'b0, 3'd4, 64'h0},                // R9 no overlap
    '{32'h000, 4'd4, 3'd3, 3'd2, 1'b0, 1'b0, 3'd4, 64'h0},                // R3 empty entry
    '{32'h100, 4'd8, 3'd1, 3'd0, 1'b1, 1'b0, 3'd3, 64'h0},                // R10 rejected
    '{32'h100, 4'd8, 3'd1, 3'd0, 1'b1, 1'b1, 3'd1, 64'h8877665544332211}  // R10 accepted
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    string tag;
    do_reset();
    // R1
    chk(!fwd_vld && !replay_vld && !cache_req_vld && !release_vld, "R1", "valids after reset",
        {fwd_vld, replay_vld, cache_req_vld, release_vld}, 0);
    chk(!stalled && !ld_blocked, "R1", "stall/blocked after reset", {stalled, ld_blocked}, 0);
    load(32'h100, 8, 0, 1, 0, 1, 0, 0);
    chk(cache_req_vld, "R1", "entries empty after reset", cache_req_vld, 1);

    preload();
    foreach (TBL[i]) begin
      load(TBL[i].addr, TBL[i].size, 3'(i), TBL[i].sqi, TBL[i].wbp, 16'(100 + i), TBL[i].unc, TBL[i].hc);
      case (TBL[i].kind)
        3'd1: tag = "R4"; 3'd2: tag = "R5"; 3'd3: tag = "R10"; default: tag = "R9";
      endcase
      chk(fwd_vld == (TBL[i].kind == 1), tag, $sformatf("row %0d fwd_vld", i), fwd_vld, TBL[i].kind == 1);
      chk(replay_vld == (TBL[i].kind == 2 || TBL[i].kind == 3), tag, $sformatf("row %0d replay_vld", i),
          replay_vld, TBL[i].kind == 2 || TBL[i].kind == 3);
      chk(replay_fault == (TBL[i].kind == 3), tag, $sformatf("row %0d replay_fault", i), replay_fault, TBL[i].kind == 3);
      chk(cache_req_vld == (TBL[i].kind == 4), tag, $sformatf("row %0d cache_req", i), cache_req_vld, TBL[i].kind == 4);
      if (TBL[i].kind == 1) begin
        chk(fwd_data == TBL[i].data, tag, $sformatf("row %0d data", i), fwd_data, TBL[i].data);
        chk(fwd_lq_idx == 3'(i), tag, $sformatf("row %0d slot", i), fwd_lq_idx, 3'(i));
      end
    end

    // R5 R7 R8: stall record and release
    do_reset();
    preload();
    load(32'h100, 4, 3, 6, 0, 50, 0, 0);
    chk(stalled && stall_st_seq == 15 && stall_lq_idx == 3, "R5", "stall record",
        {stalled, stall_st_seq, 5'(stall_lq_idx)}, {1'b1, 16'd15, 5'd3});
    load(32'h202, 4, 5, 4, 0, 40, 0, 0);
    chk(stall_st_seq == 13 && stall_lq_idx == 5, "R7", "older load replaces",
        {stall_st_seq, 5'(stall_lq_idx)}, {16'd13, 5'd5});
    load(32'h100, 4, 6, 6, 0, 60, 0, 0);
    chk(stall_st_seq == 13 && stall_lq_idx == 5, "R7", "younger load keeps",
        {stall_st_seq, 5'(stall_lq_idx)}, {16'd13, 5'd5});
    done_store(5);
    chk(stalled && !release_vld, "R8", "other store done", {stalled, release_vld}, 2'b10);
    done_store(3);
    chk(!stalled && release_vld && release_lq_idx == 5, "R8", "release",
        {stalled, release_vld, release_lq_idx}, {1'b0, 1'b1, 3'd5});
    @(negedge clk);
    chk(!release_vld, "R8", "release is one pulse", release_vld, 0);

    // R6 R8: completion and a new search over the same store in one cycle
    load(32'h0FC, 8, 2, 1, 0, 70, 0, 0);
    chk(stalled && stall_st_seq == 10 && replay_vld, "R5", "stall on word store",
        {stalled, replay_vld, stall_st_seq}, {1'b1, 1'b1, 16'd10});
    @(negedge clk);
    st_done_en = 1; st_done_idx = 0;
    ld_valid = 1; ld_addr = 32'h0FC; ld_size = 8; ld_lq_idx = 4; ld_sq_idx = 1; wb_ptr = 0; ld_seq = 71;
    @(negedge clk);
    st_done_en = 0; ld_valid = 0;
    chk(release_vld && release_lq_idx == 2, "R8", "same-cycle release", {release_vld, release_lq_idx}, {1'b1, 3'd2});
    chk(cache_req_vld && cache_req_lq_idx == 4 && !replay_vld, "R6", "same-cycle completion bypass",
        {cache_req_vld, replay_vld, cache_req_lq_idx}, {1'b1, 1'b0, 3'd4});
    chk(!stalled, "R8", "stall cleared", stalled, 0);

    // R11: blocked cache
    cache_blocked = 1;
    load(32'h600, 8, 1, 4, 0, 80, 0, 0);
    chk(!cache_req_vld && !fwd_vld && !replay_vld, "R11", "no request when blocked",
        {cache_req_vld, fwd_vld, replay_vld}, 0);
    chk(ld_blocked && ld_blocked_seq == 80, "R11", "blocked record", {ld_blocked, ld_blocked_seq}, {1'b1, 16'd80});
    load(32'h600, 8, 2, 4, 0, 90, 0, 0);
    chk(ld_blocked_seq == 80, "R11", "younger keeps record", ld_blocked_seq, 80);
    load(32'h600, 8, 3, 4, 0, 70, 0, 0);
    chk(ld_blocked_seq == 70, "R11", "older replaces record", ld_blocked_seq, 70);
    cache_blocked = 0;
    @(negedge clk); blk_clear = 1;
    @(negedge clk); blk_clear = 0;
    chk(!ld_blocked, "R11", "clear", ld_blocked, 0);

    // R3: freed entry no longer forwards
    load(32'h100, 8, 1, 1, 0, 95, 0, 0);
    chk(fwd_vld, "R3", "before free", fwd_vld, 1);
    @(negedge clk); st_free_en = 1; st_free_idx = 0;
    @(negedge clk); st_free_en = 0;
    load(32'h100, 8, 1, 1, 0, 96, 0, 0);
    chk(!fwd_vld && cache_req_vld, "R3", "after free", {fwd_vld, cache_req_vld}, 2'b01);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule